// File: doc/BRIEF.md
# Reload-and-Match PWM Timer

An up-counting timer that turns two programmed counts into a pulse-width-modulated output. The counter starts from a programmed reload count and climbs to its all-ones value. On the cycle after all-ones it takes the reload count again. The distance from the reload count to all-ones therefore sets the period. A second programmed count, the match count, marks the last cycle of the active phase. The output is active from the reload cycle through the match cycle. It is inactive from the cycle after the match up to and including the all-ones cycle.

Software programs the block through a small write port. The write port holds the reload and match counts and a control word. The control word starts or stops the timer, picks the output polarity and clears the error flag. A read port returns the two counts and a status word. A configuration is legal only when reload ≤ match < all-ones. An illegal configuration is reported, and the output stays at its inactive level while it is present.

The two counts may be changed only while the timer is stopped. This rule keeps every period built from a single set of values. A write to either count while the timer runs is dropped, and it sets a sticky error bit.

Top module: `rm_pwm_timer`

## Requirements
- R1: After reset the timer is stopped, the reload and match registers both hold all-ones minus one, polarity is 0, the error bit is 0, the invalid flag is 0 and `pwm_out` is 0.
- R2: A control write (address 2) with bit 0 set while stopped starts the timer: from the next cycle the counter holds the reload count and the output is at its active level.
- R3: While running, the counter rises by one each cycle, and after all-ones it takes the reload count again, so one period lasts (all-ones − reload + 1) cycles.
- R4: Within each period the output is active for (match − reload + 1) cycles, starting at the reload cycle, and inactive for the remaining (all-ones − match) cycles.
- R5: When reload > match or match equals all-ones, `cfg_bad` is 1 and the output is held at its inactive level.
- R6: A control write with bit 0 clear stops the timer. From the next cycle the output is at its inactive level and the counter is frozen. A later start reloads the counter.
- R7: Control bit 1 selects polarity. With 0 the active level is 1. With 1 the output is inverted, so the inactive level is 1.
- R8: A write to the reload register (address 0) or the match register (address 1) while running leaves that register unchanged and sets the sticky error bit. The error bit stays set until a control write with bit 2 set clears it.
- R9: The read port returns the reload count at address 0 and the match count at address 1. At address 2 it returns status: bit 0 running, bit 1 polarity, bit 2 error, bit 3 invalid. Address 3 reads 0.
- R10: The reset counts give the shortest legal waveform: a 2-cycle period with 1 active cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 reload, 1 match, 2 control |
| wr_data | input | WIDTH | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | WIDTH | Combinational read data |
| pwm_out | output | 1 | PWM output |
| cfg_bad | output | 1 | Current reload/match pair is illegal |

## Verification
The bench builds the timer with `WIDTH = 8`, so all-ones is 255 and no period is longer than 256 cycles. With that width, whole waveforms over two consecutive periods can be compared cycle by cycle. The extremes are all in reach: reload 0, match equal to reload, match one below all-ones, and the reset 2-cycle period. The default 32-bit width is only elaborated. The bench does not run it, because its periods are too long to observe.

// File: rtl/rm_pwm_pkg.sv
package rm_pwm_pkg;
    typedef enum logic [1:0] {
        SEL_LOAD  = 2'd0,
        SEL_MATCH = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    localparam int CTRL_RUN = 0;
    localparam int CTRL_POL = 1;
    localparam int CTRL_CLR = 2;

    localparam int STAT_RUN = 0;
    localparam int STAT_POL = 1;
    localparam int STAT_ERR = 2;
    localparam int STAT_BAD = 3;
endpackage

// File: rtl/rm_pwm_regs.sv
module rm_pwm_regs
    import rm_pwm_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] load_o,
    output logic [WIDTH-1:0] match_o,
    output logic             run_o,
    output logic             pol_o,
    output logic             err_o,
    output logic             start_o
);
    localparam logic [WIDTH-1:0] RST_COUNT = {{(WIDTH-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic [WIDTH-1:0] load;
        logic [WIDTH-1:0] match;
        logic             run;
        logic             pol;
        logic             err;
    } regs_t;

    regs_t    regs_d, regs_q;
    reg_sel_e sel;
    logic     start_d;

    assign sel = reg_sel_e'(wr_addr);

    always_comb begin
        regs_d  = regs_q;
        start_d = 1'b0;
        if (wr_en) begin
            unique case (sel)
                SEL_LOAD: begin
                    if (regs_q.run) regs_d.err  = 1'b1;
                    else            regs_d.load = wr_data;
                end
                SEL_MATCH: begin
                    if (regs_q.run) regs_d.err   = 1'b1;
                    else            regs_d.match = wr_data;
                end
                SEL_CTRL: begin
                    regs_d.run = wr_data[CTRL_RUN];
                    regs_d.pol = wr_data[CTRL_POL];
                    if (wr_data[CTRL_CLR]) regs_d.err = 1'b0;
                    start_d = wr_data[CTRL_RUN] && !regs_q.run;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{load: RST_COUNT, match: RST_COUNT, run: 1'b0, pol: 1'b0, err: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign load_o  = regs_q.load;
    assign match_o = regs_q.match;
    assign run_o   = regs_q.run;
    assign pol_o   = regs_q.pol;
    assign err_o   = regs_q.err;
    assign start_o = start_d;

    // R8
    load_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && wr_en && sel == SEL_LOAD) |=> ($stable(load_o) && err_o));

    // R8
    match_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && wr_en && sel == SEL_MATCH) |=> ($stable(match_o) && err_o));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !(wr_en && sel == SEL_CTRL && wr_data[CTRL_CLR])) |=> err_o);
endmodule

// File: rtl/rm_pwm_counter.sv
module rm_pwm_counter #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             run_i,
    input  logic [WIDTH-1:0] load_i,
    output logic [WIDTH-1:0] cnt_o
);
    localparam logic [WIDTH-1:0] ALL_ONES  = '1;
    localparam logic [WIDTH-1:0] RST_COUNT = {{(WIDTH-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d.cnt = load_i;
        end else if (run_i) begin
            if (cnt_q.cnt == ALL_ONES) cnt_d.cnt = load_i;
            else                       cnt_d.cnt = cnt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '{cnt: RST_COUNT};
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q.cnt;

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_o == $past(load_i)));

    // R3
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !start_i && cnt_o == ALL_ONES) |=> (cnt_o == $past(load_i)));

    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !start_i && cnt_o != ALL_ONES) |=> (cnt_o == $past(cnt_o) + 1'b1));

    // R6
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !start_i) |=> $stable(cnt_o));
endmodule

// File: rtl/rm_pwm_shaper.sv
module rm_pwm_shaper #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             pol_i,
    input  logic [WIDTH-1:0] cnt_i,
    input  logic [WIDTH-1:0] load_i,
    input  logic [WIDTH-1:0] match_i,
    output logic             pwm_o,
    output logic             bad_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    logic bad;
    logic active;

    always_comb begin
        bad    = (load_i > match_i) || (match_i == ALL_ONES);
        active = run_i && !bad && (cnt_i >= load_i) && (cnt_i <= match_i);
    end

    assign pwm_o = active ^ pol_i;
    assign bad_o = bad;

    // R5
    bad_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_o |-> (pwm_o == pol_i));

    // R6
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> (pwm_o == pol_i));

    // R4
    load_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !bad_o && cnt_i == load_i) |-> (pwm_o != pol_i));

    // R4
    tail_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && cnt_i == ALL_ONES) |-> (pwm_o == pol_i));
endmodule

// File: rtl/rm_pwm_timer.sv
module rm_pwm_timer
    import rm_pwm_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [WIDTH-1:0] rd_data,
    output logic             pwm_out,
    output logic             cfg_bad
);
    logic [WIDTH-1:0] load_w, match_w, cnt_w;
    logic             run_w, pol_w, err_w, start_w, bad_w;

    rm_pwm_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load_o  (load_w),
        .match_o (match_w),
        .run_o   (run_w),
        .pol_o   (pol_w),
        .err_o   (err_w),
        .start_o (start_w)
    );

    rm_pwm_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_w),
        .run_i   (run_w),
        .load_i  (load_w),
        .cnt_o   (cnt_w)
    );

    rm_pwm_shaper #(.WIDTH(WIDTH)) u_shape (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_w),
        .pol_i   (pol_w),
        .cnt_i   (cnt_w),
        .load_i  (load_w),
        .match_i (match_w),
        .pwm_o   (pwm_out),
        .bad_o   (bad_w)
    );

    assign cfg_bad = bad_w;

    always_comb begin
        rd_data = '0;
        unique case (reg_sel_e'(rd_addr))
            SEL_LOAD:  rd_data = load_w;
            SEL_MATCH: rd_data = match_w;
            SEL_CTRL: begin
                rd_data[STAT_RUN] = run_w;
                rd_data[STAT_POL] = pol_w;
                rd_data[STAT_ERR] = err_w;
                rd_data[STAT_BAD] = bad_w;
            end
            default: rd_data = '0;
        endcase
    end

    // R2
    start_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_w && !bad_w && !(wr_en && wr_data[CTRL_POL] != pol_w)) |=> (run_w && (pwm_out != pol_w || cfg_bad)));
endmodule

// File: tb/sim_rm_pwm_timer.sv
module sim_rm_pwm_timer;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = '0;
    logic [W-1:0] rd_data;
    logic         pwm_out;
    logic         cfg_bad;

    int total = 0;
    int bad = 0;

    rm_pwm_timer #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out), .cfg_bad(cfg_bad)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic exp_pwm(int ld, int mt, logic pol, int k);
        int per = MAXV - ld + 1;
        int idx = k % per;
        return ((idx <= mt - ld) ? 1'b1 : 1'b0) ^ pol;
    endfunction

    function automatic logic exp_bad(int ld, int mt);
        return (ld > mt) || (mt == MAXV);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    // program while stopped, start, compare two full periods
    task automatic wave(input string req, input int ld, input int mt, input logic pol);
        int per = MAXV - ld + 1;
        int miss = 0;
        int first_k = -1;
        logic first_act = 1'b0;
        wr(2'd0, ld);
        wr(2'd1, mt);
        wr(2'd2, 1 | (int'(pol) << 1));
        for (int k = 0; k < 2 * per; k++) begin
            if (pwm_out !== exp_pwm(ld, mt, pol, k)) begin
                if (first_k < 0) begin first_k = k; first_act = pwm_out; end
                miss++;
            end
            @(negedge clk);
        end
        total++;
        if (miss != 0) begin
            bad++;
            $display("FAIL %s load=%0d match=%0d pol=%0d cycle=%0d actual=%0b expected=%0b",
                     req, ld, mt, pol, first_k, first_act, exp_pwm(ld, mt, pol, first_k));
        end
        wr(2'd2, int'(pol) << 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v;
        int ld, mt;
        logic pol;
        v = int'($urandom(32'd24680));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 load", v, MAXV - 1);
        rd(2'd1, v); chk("R1 match", v, MAXV - 1);
        rd(2'd2, v); chk("R1 status", v, 0);
        chk("R1 pwm", int'(pwm_out), 0);
        chk("R1 cfg_bad", int'(cfg_bad), 0);

        // R10 default 2-cycle period, R2 start
        wave("R10 default", MAXV - 1, MAXV - 1, 1'b0);

        // R4 corners
        wave("R4 match==load", 40, 40, 1'b0);
        wave("R4 match==max-1", 30, MAXV - 1, 1'b0);
        wave("R3 load zero", 0, 0, 1'b0);
        // R7 polarity
        wave("R7 inverted", 200, 220, 1'b1);

        // R9 readback
        wr(2'd0, 17); wr(2'd1, 99);
        rd(2'd0, v); chk("R9 load", v, 17);
        rd(2'd1, v); chk("R9 match", v, 99);
        rd(2'd3, v); chk("R9 addr3", v, 0);

        // R6 stop: inactive, restart reloads
        wr(2'd2, 1);
        repeat (3) @(negedge clk);
        chk("R6 running active", int'(pwm_out), 1);
        wr(2'd2, 0);
        for (int i = 0; i < 4; i++) begin
            chk("R6 stopped idle", int'(pwm_out), 0);
            @(negedge clk);
        end
        wr(2'd2, 2);
        chk("R6 R7 stopped idle inverted", int'(pwm_out), 1);

        // R8 locked while running
        wr(2'd2, 1);
        wr(2'd0, 5);
        wr(2'd1, 6);
        rd(2'd0, v); chk("R8 load kept", v, 17);
        rd(2'd1, v); chk("R8 match kept", v, 99);
        rd(2'd2, v); chk("R8 err set", (v >> 2) & 1, 1);
        wr(2'd2, 1);
        rd(2'd2, v); chk("R8 err sticky", (v >> 2) & 1, 1);
        wr(2'd2, 1 | 4);
        rd(2'd2, v); chk("R8 err cleared", v, 1);
        wr(2'd2, 0);

        // R5 invalid configurations
        wr(2'd0, 80); wr(2'd1, 50);
        chk("R5 bad load>match", int'(cfg_bad), 1);
        wr(2'd1, MAXV);
        chk("R5 bad match max", int'(cfg_bad), 1);
        wr(2'd2, 1);
        for (int i = 0; i < 6; i++) begin
            chk("R5 held idle", int'(pwm_out), 0);
            @(negedge clk);
        end
        rd(2'd2, v); chk("R5 status bit3", (v >> 3) & 1, 1);
        wr(2'd2, 0);

        // random configurations, R3 R4 R5 R7
        for (int n = 0; n < 24; n++) begin
            ld  = int'($urandom_range(0, MAXV - 1));
            pol = 1'($urandom_range(0, 1));
            if (n % 4 == 3) begin
                mt = (ld > 0) ? int'($urandom_range(0, ld - 1)) : MAXV;
                wr(2'd0, ld); wr(2'd1, mt);
                chk("R5 random flag", int'(cfg_bad), int'(exp_bad(ld, mt)));
                wr(2'd2, 1 | (int'(pol) << 1));
                repeat (2) @(negedge clk);
                chk("R5 random idle", int'(pwm_out), int'(pol));
                wr(2'd2, int'(pol) << 1);
            end else begin
                mt = int'($urandom_range(ld, MAXV - 1));
                wave("R4 random", ld, mt, pol);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule